// File: doc/BRIEF.md
# Serial Programming-Mode Entry/Exit Sequencer

This block moves a target device into and out of its low-voltage serial programming mode by driving four lines: the target's active-low reset, a serial data line, a serial clock line and an optional power-enable line. On a start request it charges the lines, switches power on, pulses reset, and then clocks out a fixed 32-bit unlock key one bit per clock pulse, most significant bit first. After that it raises reset and waits out the hold time. Only then does it report ready, so a command engine can take over the data and clock lines.

On a stop request from the ready state, the sequencer parks data and clock low and pulls reset low. It then releases data and clock to high impedance and raises reset. Every interval is a parameter counted in system-clock cycles. A power-disable input, sampled with the start request, skips the precharge and power steps for targets that are powered elsewhere.

Top module: `prog_entry_seq`

## Requirements
- R1: After reset the block is idle: busy_o=0 and ready_o=0. Both output enables are 0, tgt_rst_n_o=1, tgt_clk_o=0, tgt_dat_o=0 and tgt_pwr_en_o=0.
- R2: If no_power_i=0 when start_i is accepted, the block spends T_PRECH_CYC cycles with both enables on and data, clock and reset all 1, while power stays off.
- R3: Next, power turns on and reset, data and clock are driven 0 for T_VDD_CYC cycles. Reset then goes to 1 for T_PULSE_CYC cycles and returns to 0.
- R4: The key phase starts T_KEYDLY_CYC cycles after that fall of reset, and reset stays 0 during every key clock pulse.
- R5: The key 32'h4D434850 is sent most significant bit first. Each bit gets one clock pulse, made of T_KLO_CYC low cycles followed by T_KHI_CYC high cycles.
- R6: Data changes only one cycle after the clock falls. It is therefore stable for T_KLO_CYC-1 cycles before each rise and through each fall.
- R7: After the last clock high phase, the clock stays low for T_GAP_CYC cycles. Reset then rises and, T_HOLD_CYC cycles later, ready_o=1 and busy_o=0 while all lines stay driven.
- R8: A stop request in the ready state first drives data and clock low with reset at 1 for T_EXDRV_CYC cycles. Reset is then driven 0 for T_EXRST_CYC cycles. Finally the block returns to idle, with enables 0, reset 1 and power off.
- R9: If no_power_i=1 when start is accepted, there is no precharge and power stays off for the whole session. The rest of the timing is unchanged.
- R10: The block ignores start and stop while busy, ignores start while ready, ignores stop while idle, and ignores changes to no_power_i after start is accepted.
- R11: busy_o is 1 from the cycle after an accepted start until ready, and again from an accepted stop until idle. busy_o and ready_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to enter programming mode |
| stop_i | input | 1 | Request to leave programming mode |
| no_power_i | input | 1 | 1 = skip precharge and power switching |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Target is in programming mode |
| tgt_rst_n_o | output | 1 | Target reset, active low |
| tgt_clk_o | output | 1 | Serial clock to target |
| tgt_clk_oe_o | output | 1 | Serial clock output enable |
| tgt_dat_o | output | 1 | Serial data to target |
| tgt_dat_oe_o | output | 1 | Serial data output enable |
| tgt_pwr_en_o | output | 1 | Target power enable, active high |

## Verification
Each session's full line waveform is compared cycle by cycle with a timeline that the bench derives arithmetically from the interval parameters. Three entry patterns are used. A clean powered entry confirms the phase order and lengths. An unpowered entry tells whether the power steps are really skipped or only masked. An entry with start, stop and power-disable toggled almost every cycle shows whether any request leaks into a running sequence. The key is also rebuilt from the data value seen at each clock rise, which catches bit-order and off-by-one errors that a per-phase check could miss. Stop in idle and start in ready are each applied and then watched at the lines.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRECH,
    ST_PWRUP,
    ST_RPULSE,
    ST_RLOW,
    ST_KLO,
    ST_KHI,
    ST_GAP,
    ST_HOLD,
    ST_READY,
    ST_EXDRV,
    ST_EXRST
  } seq_state_t;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0 .. v-1
  function automatic int unsigned cnt_width(int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_o,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign expired = (cnt_q == '0);
endmodule

// File: rtl/key_serializer.sv
module key_serializer #(
  parameter int unsigned       KEY_BITS  = 32,
  parameter logic [KEY_BITS-1:0] KEY_VALUE = 32'h4D434850
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic bit_o,
  output logic last_o
);
  localparam int unsigned IW = prog_seq_pkg::cnt_width(KEY_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(KEY_BITS - 1);

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (clr) idx_q <= '0;
    else if (adv) idx_q <= idx_q + 1'b1;
  end

  // index 0 selects the most significant key bit
  assign bit_o  = KEY_VALUE[LAST_IDX - idx_q];
  assign last_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/prog_entry_seq.sv
module prog_entry_seq #(
  parameter int unsigned         T_PRECH_CYC  = 1000000,
  parameter int unsigned         T_VDD_CYC    = 10,
  parameter int unsigned         T_PULSE_CYC  = 10,
  parameter int unsigned         T_KEYDLY_CYC = 40000,
  parameter int unsigned         T_KLO_CYC    = 2,
  parameter int unsigned         T_KHI_CYC    = 2,
  parameter int unsigned         T_GAP_CYC    = 10,
  parameter int unsigned         T_HOLD_CYC   = 4000,
  parameter int unsigned         T_EXDRV_CYC  = 10,
  parameter int unsigned         T_EXRST_CYC  = 30,
  parameter int unsigned         KEY_BITS     = 32,
  parameter logic [KEY_BITS-1:0] KEY_VALUE    = 32'h4D434850
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic no_power_i,
  output logic busy_o,
  output logic ready_o,
  output logic tgt_rst_n_o,
  output logic tgt_clk_o,
  output logic tgt_clk_oe_o,
  output logic tgt_dat_o,
  output logic tgt_dat_oe_o,
  output logic tgt_pwr_en_o
);
  import prog_seq_pkg::*;

  // T_KLO_CYC must be at least 2 so data has one cycle of hold and one of setup
  localparam int unsigned DMAX = max2(max2(max2(T_PRECH_CYC, T_KEYDLY_CYC),
                                           max2(T_HOLD_CYC, T_EXRST_CYC)),
                                      max2(max2(T_VDD_CYC, T_PULSE_CYC),
                                           max2(max2(T_KLO_CYC, T_KHI_CYC),
                                                max2(T_GAP_CYC, T_EXDRV_CYC))));
  localparam int unsigned CW = cnt_width(DMAX);
  localparam logic [CW-1:0] KLO_FIRST = CW'(T_KLO_CYC - 1);

  seq_state_t    state_q, state_d;
  logic          use_pwr_q;
  logic          dat_q;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic [CW-1:0] tmr_cnt;
  logic          tmr_done;
  logic          key_bit;
  logic          key_last;
  logic          key_adv;
  logic          key_clr;

  // named internal events
  wire key_phase  = (state_q == ST_KLO) || (state_q == ST_KHI);
  wire bit_load   = (state_q == ST_KLO) && (tmr_cnt == KLO_FIRST);
  wire lines_idle = (state_q == ST_IDLE);

  function automatic logic [CW-1:0] dur_m1(seq_state_t s);
    int unsigned d;
    case (s)
      ST_PRECH:  d = T_PRECH_CYC;
      ST_PWRUP:  d = T_VDD_CYC;
      ST_RPULSE: d = T_PULSE_CYC;
      ST_RLOW:   d = T_KEYDLY_CYC;
      ST_KLO:    d = T_KLO_CYC;
      ST_KHI:    d = T_KHI_CYC;
      ST_GAP:    d = T_GAP_CYC;
      ST_HOLD:   d = T_HOLD_CYC;
      ST_EXDRV:  d = T_EXDRV_CYC;
      ST_EXRST:  d = T_EXRST_CYC;
      default:   d = 1;
    endcase
    return CW'(d - 1);
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_i) state_d = no_power_i ? ST_PWRUP : ST_PRECH;
      ST_PRECH:  if (tmr_done) state_d = ST_PWRUP;
      ST_PWRUP:  if (tmr_done) state_d = ST_RPULSE;
      ST_RPULSE: if (tmr_done) state_d = ST_RLOW;
      ST_RLOW:   if (tmr_done) state_d = ST_KLO;
      ST_KLO:    if (tmr_done) state_d = ST_KHI;
      ST_KHI:    if (tmr_done) state_d = key_last ? ST_GAP : ST_KLO;
      ST_GAP:    if (tmr_done) state_d = ST_HOLD;
      ST_HOLD:   if (tmr_done) state_d = ST_READY;
      ST_READY:  if (stop_i) state_d = ST_EXDRV;
      ST_EXDRV:  if (tmr_done) state_d = ST_EXRST;
      ST_EXRST:  if (tmr_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign tmr_val  = dur_m1(state_d);
  assign key_adv  = (state_q == ST_KHI) && tmr_done && !key_last;
  assign key_clr  = (state_q == ST_RLOW);

  seq_timer #(.W(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt_o    (tmr_cnt),
    .expired  (tmr_done)
  );

  key_serializer #(.KEY_BITS(KEY_BITS), .KEY_VALUE(KEY_VALUE)) u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (key_clr),
    .adv    (key_adv),
    .bit_o  (key_bit),
    .last_o (key_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      use_pwr_q <= 1'b0;
      dat_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (lines_idle && start_i) use_pwr_q <= !no_power_i;
      if (bit_load)                                 dat_q <= key_bit;
      else if (!key_phase && state_q != ST_GAP)     dat_q <= 1'b0;
    end
  end

  always_comb begin
    tgt_clk_oe_o = 1'b1;
    tgt_rst_n_o  = 1'b0;
    tgt_clk_o    = 1'b0;
    tgt_dat_o    = dat_q;
    busy_o       = 1'b1;
    ready_o      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        tgt_clk_oe_o = 1'b0;
        tgt_rst_n_o  = 1'b1;
        busy_o       = 1'b0;
      end
      ST_PRECH: begin
        tgt_rst_n_o = 1'b1;
        tgt_clk_o   = 1'b1;
        tgt_dat_o   = 1'b1;
      end
      ST_RPULSE, ST_HOLD, ST_EXDRV: tgt_rst_n_o = 1'b1;
      ST_KHI:   tgt_clk_o = 1'b1;
      ST_READY: begin
        tgt_rst_n_o = 1'b1;
        busy_o      = 1'b0;
        ready_o     = 1'b1;
      end
      default: ;
    endcase
  end

  assign tgt_dat_oe_o = tgt_clk_oe_o;
  assign tgt_pwr_en_o = use_pwr_q && !lines_idle && (state_q != ST_PRECH);

endmodule

// File: rtl/prog_entry_seq_chk.sv
module prog_entry_seq_chk #(
  parameter int unsigned KEYDLY = 4,
  parameter int unsigned HOLD   = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic stop_i,
  input logic busy_o,
  input logic ready_o,
  input logic tgt_rst_n_o,
  input logic tgt_clk_o,
  input logic tgt_clk_oe_o,
  input logic tgt_dat_o,
  input logic tgt_pwr_en_o,
  input logic key_phase
);
  logic        rst_prev_q;
  logic [31:0] since_fall_q;
  logic [31:0] since_rise_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_prev_q   <= 1'b1;
      since_fall_q <= '0;
      since_rise_q <= '0;
    end else begin
      rst_prev_q <= tgt_rst_n_o;
      if (rst_prev_q && !tgt_rst_n_o)    since_fall_q <= 32'd1;
      else if (since_fall_q != '1)       since_fall_q <= since_fall_q + 1;
      if (!rst_prev_q && tgt_rst_n_o)    since_rise_q <= 32'd1;
      else if (since_rise_q != '1)       since_rise_q <= since_rise_q + 1;
    end
  end

  p_busy_ready_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && ready_o));

  p_start_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !ready_o && start_i) |=> busy_o);

  p_prech_unpowered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tgt_clk_oe_o && tgt_rst_n_o && tgt_clk_o && tgt_dat_o) |-> !tgt_pwr_en_o);

  p_key_rst_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tgt_clk_o) && $past(tgt_clk_oe_o)) |-> !tgt_rst_n_o);

  p_key_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tgt_clk_o) && $past(tgt_clk_oe_o)) |-> (since_fall_q >= KEYDLY));

  p_data_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tgt_clk_o) && $past(tgt_clk_oe_o)) |-> $stable(tgt_dat_o));

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tgt_clk_o) && key_phase) |-> $stable(tgt_dat_o));

  p_hold_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (tgt_rst_n_o && since_rise_q >= HOLD));

  p_exit_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && stop_i) |=> (busy_o && !tgt_clk_o && !tgt_dat_o && tgt_rst_n_o));

  p_start_in_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !stop_i) |=> ready_o);

endmodule

bind prog_entry_seq prog_entry_seq_chk #(
  .KEYDLY (T_KEYDLY_CYC),
  .HOLD   (T_HOLD_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .busy_o       (busy_o),
  .ready_o      (ready_o),
  .tgt_rst_n_o  (tgt_rst_n_o),
  .tgt_clk_o    (tgt_clk_o),
  .tgt_clk_oe_o (tgt_clk_oe_o),
  .tgt_dat_o    (tgt_dat_o),
  .tgt_pwr_en_o (tgt_pwr_en_o),
  .key_phase    (key_phase)
);

// File: tb/test_prog_entry_seq.sv
module test_prog_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 5, VDD = 3, PUL = 2, KDL = 7, KLO = 2, KHI = 3;
  localparam int GAP = 2, HLD = 6, EXD = 2, EXR = 3;
  localparam logic [31:0] KEY = 32'h4D434850;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, no_power_i = 1'b0;
  logic busy_o, ready_o, tgt_rst_n_o, tgt_clk_o, tgt_clk_oe_o;
  logic tgt_dat_o, tgt_dat_oe_o, tgt_pwr_en_o;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;
  logic [31:0] key_acc = '0;
  int key_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_entry_seq #(
    .T_PRECH_CYC(PRE), .T_VDD_CYC(VDD), .T_PULSE_CYC(PUL), .T_KEYDLY_CYC(KDL),
    .T_KLO_CYC(KLO), .T_KHI_CYC(KHI), .T_GAP_CYC(GAP), .T_HOLD_CYC(HLD),
    .T_EXDRV_CYC(EXD), .T_EXRST_CYC(EXR)
  ) i_prog_entry_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .no_power_i(no_power_i), .busy_o(busy_o), .ready_o(ready_o),
    .tgt_rst_n_o(tgt_rst_n_o), .tgt_clk_o(tgt_clk_o), .tgt_clk_oe_o(tgt_clk_oe_o),
    .tgt_dat_o(tgt_dat_o), .tgt_dat_oe_o(tgt_dat_oe_o), .tgt_pwr_en_o(tgt_pwr_en_o)
  );

  // rebuild the key from data seen at each driven clock rise (R5)
  always @(posedge tgt_clk_o)
    if (tgt_clk_oe_o && !tgt_rst_n_o) begin
      key_acc = {key_acc[30:0], tgt_dat_o};
      key_cnt++;
    end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT && !finished) begin
      total++; bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {clk_oe, dat_oe, rst_n, clk, dat, pwr, busy, ready}
  function automatic logic [7:0] pack(bit oe, bit rs, bit ck, bit dt, bit pw, bit bz, bit rd);
    return {oe, oe, rs, ck, dt, pw, bz, rd};
  endfunction

  function automatic logic [7:0] actual();
    return {tgt_clk_oe_o, tgt_dat_oe_o, tgt_rst_n_o, tgt_clk_o, tgt_dat_o,
            tgt_pwr_en_o, busy_o, ready_o};
  endfunction

  function automatic bit kbit(int i);
    return KEY[31 - i];
  endfunction

  function automatic int ready_at(bit pwr);
    return (pwr ? PRE : 0) + VDD + PUL + KDL + 32 * (KLO + KHI) + GAP + HLD;
  endfunction

  // expected lines t cycles after an accepted start
  function automatic logic [7:0] exp_entry(int t, bit pwr, output string tag);
    int p, b, r;
    p = pwr ? PRE : 0;
    if (t < p) begin tag = "R2"; return pack(1,1,1,1,0,1,0); end
    t -= p;
    if (t < VDD) begin tag = "R3"; return pack(1,0,0,0,pwr,1,0); end
    t -= VDD;
    if (t < PUL) begin tag = "R3"; return pack(1,1,0,0,pwr,1,0); end
    t -= PUL;
    if (t < KDL) begin tag = "R4"; return pack(1,0,0,0,pwr,1,0); end
    t -= KDL;
    if (t < 32 * (KLO + KHI)) begin
      b = t / (KLO + KHI); r = t % (KLO + KHI);
      if (r == 0) begin
        tag = "R6";
        return pack(1,0,0,(b == 0) ? 1'b0 : kbit(b-1),pwr,1,0);
      end
      tag = "R5";
      return pack(1,0,(r >= KLO),kbit(b),pwr,1,0);
    end
    t -= 32 * (KLO + KHI);
    if (t < GAP) begin tag = "R7"; return pack(1,0,0,kbit(31),pwr,1,0); end
    t -= GAP;
    if (t < HLD) begin tag = "R7"; return pack(1,1,0,0,pwr,1,0); end
    tag = "R7";
    return pack(1,1,0,0,pwr,0,1);
  endfunction

  function automatic logic [7:0] exp_exit(int u, bit pwr);
    if (u < EXD) return pack(1,1,0,0,pwr,1,0);
    if (u < EXD + EXR) return pack(1,0,0,0,pwr,1,0);
    return pack(0,1,0,0,0,0,0);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic run_entry(bit pwr, bit junk);
    string tag;
    logic [7:0] e;
    int g;
    g = ready_at(pwr);
    key_acc = '0; key_cnt = 0;
    @(negedge clk);
    start_i = 1'b1; no_power_i = !pwr;
    for (int t = 0; t <= g + 3; t++) begin
      @(negedge clk);
      e = exp_entry(t, pwr, tag);
      if (junk) tag = "R10";
      else if (!pwr) tag = "R9";
      chk(tag, actual(), e);
      if (junk && t < g - 2) begin
        start_i = (t % 2 == 0);
        stop_i = (t % 3 == 1);
        no_power_i = t[0];
      end else begin
        start_i = 1'b0; stop_i = 1'b0; no_power_i = 1'b0;
      end
    end
    total++;
    if (key_acc !== KEY || key_cnt != 32) begin
      bad++;
      $display("FAIL R5: act=%h/%0d exp=%h/32", key_acc, key_cnt, KEY);
    end
  endtask

  task automatic run_exit(bit pwr);
    @(negedge clk);
    stop_i = 1'b1;
    for (int u = 0; u < EXD + EXR + 3; u++) begin
      @(negedge clk);
      stop_i = 1'b0;
      chk("R8", actual(), exp_exit(u, pwr));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", actual(), pack(0,1,0,0,0,0,0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", actual(), pack(0,1,0,0,0,0,0));

    // stop while idle has no effect
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10", actual(), pack(0,1,0,0,0,0,0));
    end

    run_entry(1'b1, 1'b0);

    // start while ready has no effect
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10", actual(), pack(1,1,0,0,1,0,1));
    end

    run_exit(1'b1);
    run_entry(1'b0, 1'b0);
    run_exit(1'b0);
    run_entry(1'b1, 1'b1);
    run_exit(1'b1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule